// File: doc/BRIEF.md
# Byte Holding FIFO Pair with Threshold Ready Flags

This block sits between a register-mapped bus port and a serial byte engine. It buffers bytes in both directions: a transmit FIFO that the bus fills and the engine drains, and a receive FIFO that the engine fills and the bus drains. Each direction raises a ready flag when a programmable threshold is met: one entry or four entries. That flag can drive a DMA request or an interrupt.

The FIFOs start out in single-entry mode, where each direction acts as one holding register. A FIFO-on command switches both directions to `DEPTH` entries. In that mode a 32-bit bus access moves four bytes at once, with the first byte in bits 7:0. A negative acknowledge from the engine sets a sticky lock. While the lock is set, queued transmit bytes stay in the FIFO and are not offered to the engine, until software clears the lock explicitly.

The engine interfaces use valid/ready handshakes:
- On the transmit side, `eng_tx_valid` never depends on `eng_tx_ready`.
- On the receive side, `eng_rx_ready` depends only on the stored level, never on `eng_rx_valid`.
- A byte moves on a cycle where valid and ready are both high.

The bus side uses plain strobes. A rejected access is reported through sticky error flags; it never stalls.

`DEPTH` must be a power of two, no smaller than 4.

Top module: `hf_holding_fifos`

## Requirements
- R1: After reset, FIFO mode is off, both levels are 0, the lock and both error flags are clear, `tx_rdy` is 1 and `rx_rdy` is 0.
- R2: A pulse on `fifo_on_cmd` sets capacity to `DEPTH`, and a pulse on `fifo_off_cmd` sets it to 1. Either command empties both FIFOs. If both are pulsed in the same cycle, off wins.
- R3: `tx_rdy` is 1 when free transmit entries are at least 4 (FIFO mode with `tx_four_mode`=1), otherwise when at least 1. In single-entry mode `tx_four_mode` is ignored.
- R4: `rx_rdy` is 1 when held receive bytes are at least 4 (FIFO mode with `rx_four_mode`=1), otherwise when at least 1. In single-entry mode `rx_four_mode` is ignored.
- R5: A byte write pushes `bus_wr_data[7:0]`. A byte read pops the oldest byte and returns it in `bus_rd_data[7:0]` with the upper bits zero. Bytes leave in arrival order.
- R6: In FIFO mode a wide access moves four bytes, the first in bits 7:0 and the last in bits 31:24. The access is rejected as a whole unless all four slots or bytes are available. In single-entry mode a wide access acts as a byte access.
- R7: `tx_flush_cmd` and `rx_flush_cmd` each empty only their own direction and may be pulsed together. A bus access or engine transfer in the flushed direction in that cycle is dropped and raises no error.
- R8: `nack_set` sets `lock_flag` from the next cycle. `lock_clr_cmd` clears it, and set wins over clear. While locked, bus writes are still accepted.
- R9: A rejected bus write sets `tx_ovf_err`. A rejected bus read sets `rx_udf_err` and returns the last popped byte: zero-extended for a byte read, or copied into all four lanes for a wide read (0 before any pop). `status_rd` clears both flags, and a new event in the same cycle wins.
- R10: An engine pop in a cycle frees its slot for a bus write in that same cycle. `eng_rx_ready` is 1 exactly when the receive level is below capacity.
- R11: `eng_tx_valid` is 1 exactly when the transmit FIFO is non-empty and unlocked, and `eng_tx_data` is the oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_on_cmd | input | 1 | Pulse: switch to `DEPTH`-entry mode and empty both FIFOs |
| fifo_off_cmd | input | 1 | Pulse: switch to single-entry mode and empty both FIFOs |
| tx_flush_cmd | input | 1 | Pulse: empty the transmit FIFO |
| rx_flush_cmd | input | 1 | Pulse: empty the receive FIFO |
| lock_clr_cmd | input | 1 | Pulse: clear the transmit lock |
| tx_four_mode | input | 1 | Transmit ready threshold: 0 = one free entry, 1 = four free entries |
| rx_four_mode | input | 1 | Receive ready threshold: 0 = one held byte, 1 = four held bytes |
| bus_wr_en | input | 1 | Bus write strobe to the transmit holding address |
| bus_wr_wide | input | 1 | Write is 32-bit rather than 8-bit |
| bus_wr_data | input | 32 | Write data, first byte in bits 7:0 |
| bus_rd_en | input | 1 | Bus read strobe of the receive holding address |
| bus_rd_wide | input | 1 | Read is 32-bit rather than 8-bit |
| bus_rd_data | output | 32 | Read data, valid in the cycle of `bus_rd_en` |
| status_rd | input | 1 | Status read strobe; clears the error flags |
| eng_tx_valid | output | 1 | Transmit byte offered to the engine |
| eng_tx_ready | input | 1 | Engine takes the offered byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive FIFO can accept a byte |
| eng_rx_data | input | 8 | Received byte |
| nack_set | input | 1 | Pulse from the engine: negative acknowledge seen, set lock |
| tx_rdy | output | 1 | Transmit threshold met |
| rx_rdy | output | 1 | Receive threshold met |
| tx_level | output | $clog2(DEPTH+1) | Bytes held in the transmit FIFO |
| rx_level | output | $clog2(DEPTH+1) | Bytes held in the receive FIFO |
| lock_flag | output | 1 | Transmit lock is set |
| fifo_on | output | 1 | FIFO mode active |
| tx_ovf_err | output | 1 | Sticky: a bus write was rejected |
| rx_udf_err | output | 1 | Sticky: a bus read was rejected |

## Verification
The sharpest overlap is an engine pop and a bus write landing in the same cycle on a full transmit FIFO. The write must be accepted without an overflow, and the order of the next bytes must stay intact. This case is set up directly by filling the FIFO with the engine stalled and then raising `eng_tx_ready` together with the write strobe. It also recurs under random stimulus.

A second overlap pairs `nack_set` with `lock_clr_cmd`, and an error event with `status_rd`; in both, the set must win.

Every cycle, a queue-based model in the bench predicts the levels, flags, engine-side data and read data, and these predictions are compared at the ports.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;

  typedef enum logic {
    THR_ONE  = 1'b0,
    THR_FOUR = 1'b1
  } thr_e;
endpackage

// File: rtl/hf_byte_fifo.sv
module hf_byte_fifo
  import hf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [CW-1:0]     push_cnt,
  input  logic [WORD_W-1:0] push_data,
  input  logic [CW-1:0]     pop_cnt,
  output logic [WORD_W-1:0] peek_data,
  output logic [LW-1:0]     level
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int k = 0; k < int'(LANES); k++) begin
        if (k < int'(push_cnt)) mem[wr_ptr + PW'(k)] <= push_data[BYTE_W*k +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_cnt);
      rd_ptr <= rd_ptr + PW'(pop_cnt);
      level  <= level + LW'(push_cnt) - LW'(pop_cnt);
    end
  end

  for (genvar g = 0; g < int'(LANES); g++) begin : g_peek
    localparam logic [PW-1:0] OFS = PW'(g);
    assign peek_data[BYTE_W*g +: BYTE_W] = mem[rd_ptr + OFS];
  end
endmodule

// File: rtl/hf_thresh_flag.sv
module hf_thresh_flag #(
  parameter int unsigned LW = 5
) (
  input  logic [LW-1:0] count,
  input  logic          four_sel,
  output logic          flag
);
  always_comb begin
    if (four_sel) flag = (count >= LW'(4));
    else          flag = (count != '0);
  end
endmodule

// File: rtl/hf_sticky_flag.sv
module hf_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/hf_holding_fifos.sv
module hf_holding_fifos
  import hf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_on_cmd,
  input  logic          fifo_off_cmd,
  input  logic          tx_flush_cmd,
  input  logic          rx_flush_cmd,
  input  logic          lock_clr_cmd,
  input  logic          tx_four_mode,
  input  logic          rx_four_mode,
  input  logic          bus_wr_en,
  input  logic          bus_wr_wide,
  input  logic [31:0]   bus_wr_data,
  input  logic          bus_rd_en,
  input  logic          bus_rd_wide,
  output logic [31:0]   bus_rd_data,
  input  logic          status_rd,
  output logic          eng_tx_valid,
  input  logic          eng_tx_ready,
  output logic [7:0]    eng_tx_data,
  input  logic          eng_rx_valid,
  output logic          eng_rx_ready,
  input  logic [7:0]    eng_rx_data,
  input  logic          nack_set,
  output logic          tx_rdy,
  output logic          rx_rdy,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          lock_flag,
  output logic          fifo_on,
  output logic          tx_ovf_err,
  output logic          rx_udf_err
);
  localparam int unsigned CW = $clog2(LANES + 1);

  // mode register and derived capacity
  logic          mode_cmd;
  logic [LW-1:0] cap;

  assign mode_cmd = fifo_on_cmd | fifo_off_cmd;
  assign cap      = fifo_on ? LW'(DEPTH) : LW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)            fifo_on <= 1'b0;
    else if (fifo_off_cmd) fifo_on <= 1'b0;
    else if (fifo_on_cmd)  fifo_on <= 1'b1;
  end

  // transmit direction
  logic              tx_fl, tx_pop, tx_take, tx_wide, ovf_evt;
  logic [LW-1:0]     tx_free, tx_room, tx_need;
  logic [CW-1:0]     tx_push_cnt, tx_pop_cnt;
  logic [WORD_W-1:0] tx_peek;
  thr_e              tx_thr;

  assign tx_fl        = tx_flush_cmd | mode_cmd;
  assign eng_tx_valid = (tx_level != '0) && !lock_flag;
  assign eng_tx_data  = tx_peek[BYTE_W-1:0];
  assign tx_pop       = eng_tx_valid & eng_tx_ready;
  assign tx_free      = cap - tx_level;
  assign tx_room      = tx_free + LW'(tx_pop);
  assign tx_wide      = fifo_on & bus_wr_wide;
  assign tx_need      = tx_wide ? LW'(LANES) : LW'(1);
  assign tx_take      = bus_wr_en && !tx_fl && (tx_room >= tx_need);
  assign ovf_evt      = bus_wr_en && !tx_fl && !tx_take;
  assign tx_push_cnt  = tx_take ? (tx_wide ? CW'(LANES) : CW'(1)) : '0;
  assign tx_pop_cnt   = tx_pop ? CW'(1) : '0;
  assign tx_thr       = (fifo_on && tx_four_mode) ? THR_FOUR : THR_ONE;

  hf_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_fl),
    .push_cnt(tx_push_cnt), .push_data(bus_wr_data),
    .pop_cnt(tx_pop_cnt), .peek_data(tx_peek), .level(tx_level)
  );

  hf_thresh_flag #(.LW(LW)) u_tx_thr (
    .count(tx_free), .four_sel(tx_thr == THR_FOUR), .flag(tx_rdy)
  );

  // receive direction
  logic              rx_fl, rx_push, rx_take, rx_wide, udf_evt;
  logic [LW-1:0]     rx_need;
  logic [CW-1:0]     rx_push_cnt, rx_pop_cnt;
  logic [WORD_W-1:0] rx_peek, rx_push_data;
  logic [BYTE_W-1:0] last_byte;
  thr_e              rx_thr;

  assign rx_fl        = rx_flush_cmd | mode_cmd;
  assign eng_rx_ready = rx_level < cap;
  assign rx_push      = eng_rx_valid & eng_rx_ready;
  assign rx_wide      = fifo_on & bus_rd_wide;
  assign rx_need      = rx_wide ? LW'(LANES) : LW'(1);
  assign rx_take      = bus_rd_en && !rx_fl && (rx_level >= rx_need);
  assign udf_evt      = bus_rd_en && !rx_fl && !rx_take;
  assign rx_push_cnt  = rx_push ? CW'(1) : '0;
  assign rx_pop_cnt   = rx_take ? (rx_wide ? CW'(LANES) : CW'(1)) : '0;
  assign rx_push_data = {{(WORD_W-BYTE_W){1'b0}}, eng_rx_data};
  assign rx_thr       = (fifo_on && rx_four_mode) ? THR_FOUR : THR_ONE;

  hf_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_fl),
    .push_cnt(rx_push_cnt), .push_data(rx_push_data),
    .pop_cnt(rx_pop_cnt), .peek_data(rx_peek), .level(rx_level)
  );

  hf_thresh_flag #(.LW(LW)) u_rx_thr (
    .count(rx_level), .four_sel(rx_thr == THR_FOUR), .flag(rx_rdy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       last_byte <= '0;
    else if (rx_take) last_byte <= rx_wide ? rx_peek[WORD_W-1 -: BYTE_W] : rx_peek[BYTE_W-1:0];
  end

  always_comb begin
    if (rx_take) bus_rd_data = rx_wide ? rx_peek : {{(WORD_W-BYTE_W){1'b0}}, rx_peek[BYTE_W-1:0]};
    else         bus_rd_data = rx_wide ? {LANES{last_byte}} : {{(WORD_W-BYTE_W){1'b0}}, last_byte};
  end

  // sticky lock and error flags
  hf_sticky_flag u_lock (
    .clk(clk), .rst_n(rst_n), .set(nack_set), .clr(lock_clr_cmd), .flag(lock_flag)
  );
  hf_sticky_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .set(ovf_evt), .clr(status_rd), .flag(tx_ovf_err)
  );
  hf_sticky_flag u_udf (
    .clk(clk), .rst_n(rst_n), .set(udf_evt), .clr(status_rd), .flag(rx_udf_err)
  );
endmodule

// File: rtl/hf_holding_fifos_chk.sv
module hf_holding_fifos_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_on_cmd,
  input logic          fifo_off_cmd,
  input logic          tx_flush_cmd,
  input logic          rx_flush_cmd,
  input logic          bus_rd_en,
  input logic          status_rd,
  input logic          nack_set,
  input logic          eng_tx_valid,
  input logic          eng_rx_valid,
  input logic          eng_rx_ready,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          lock_flag,
  input logic          fifo_on,
  input logic          tx_ovf_err
);
  // R8
  locked_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag |-> !eng_tx_valid);

  // R8
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_set |=> lock_flag);

  // R2
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |-> (tx_level <= LW'(1) && rx_level <= LW'(1)));

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH)));

  // R7
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_cmd |=> (tx_level == '0));

  // R7
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_cmd |=> (rx_level == '0));

  // R10
  rx_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_valid && !eng_rx_ready && !bus_rd_en && !rx_flush_cmd && !fifo_on_cmd && !fifo_off_cmd)
    |=> $stable(rx_level));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf_err && !status_rd) |=> tx_ovf_err);

  // R11
  valid_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_valid |-> (tx_level != '0));
endmodule

bind hf_holding_fifos hf_holding_fifos_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_hf_holding_fifos.sv
module tb_hf_holding_fifos;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          fifo_on_cmd, fifo_off_cmd, tx_flush_cmd, rx_flush_cmd, lock_clr_cmd;
  logic          tx_four_mode, rx_four_mode;
  logic          bus_wr_en, bus_wr_wide, bus_rd_en, bus_rd_wide, status_rd;
  logic [31:0]   bus_wr_data, bus_rd_data;
  logic          eng_tx_valid, eng_tx_ready, eng_rx_valid, eng_rx_ready, nack_set;
  logic [7:0]    eng_tx_data, eng_rx_data;
  logic          tx_rdy, rx_rdy, lock_flag, fifo_on, tx_ovf_err, rx_udf_err;
  logic [LW-1:0] tx_level, rx_level;

  hf_holding_fifos #(.DEPTH(DEPTH)) dut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit m_on, m_lock, m_ovf, m_udf;
  logic [7:0] m_last;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_tx_rdy(int cap, int ts);
    return (m_on && tx_four_mode) ? (cap - ts >= 4) : (cap - ts >= 1);
  endfunction

  function automatic bit exp_rx_rdy(int rs);
    return (m_on && rx_four_mode) ? (rs >= 4) : (rs >= 1);
  endfunction

  task automatic idle();
    fifo_on_cmd = 0; fifo_off_cmd = 0; tx_flush_cmd = 0; rx_flush_cmd = 0;
    lock_clr_cmd = 0; bus_wr_en = 0; bus_wr_wide = 0; bus_wr_data = '0;
    bus_rd_en = 0; bus_rd_wide = 0; status_rd = 0; eng_tx_ready = 0;
    eng_rx_valid = 0; eng_rx_data = '0; nack_set = 0;
  endtask

  // inputs are set just after a falling edge; this samples, checks, advances the model
  task automatic cycle();
    int cap, ts, rs, room, need, rneed;
    bit exp_v, tx_pop, tx_acc, ovf_evt, rx_acc, udf_evt, rx_push, txfl, rxfl;
    logic [31:0] exp_rd;
    #1;
    cap = m_on ? DEPTH : 1;
    ts = txq.size();
    rs = rxq.size();
    chk("R5 tx_level", 32'(tx_level), 32'(ts));
    chk("R5 rx_level", 32'(rx_level), 32'(rs));
    chk("R3 tx_rdy", 32'(tx_rdy), 32'(exp_tx_rdy(cap, ts)));
    chk("R4 rx_rdy", 32'(rx_rdy), 32'(exp_rx_rdy(rs)));
    exp_v = (ts > 0) && !m_lock;
    chk("R11 eng_tx_valid", 32'(eng_tx_valid), 32'(exp_v));
    if (exp_v) chk("R11 eng_tx_data", 32'(eng_tx_data), 32'(txq[0]));
    chk("R8 lock_flag", 32'(lock_flag), 32'(m_lock));
    chk("R2 fifo_on", 32'(fifo_on), 32'(m_on));
    chk("R9 tx_ovf_err", 32'(tx_ovf_err), 32'(m_ovf));
    chk("R9 rx_udf_err", 32'(rx_udf_err), 32'(m_udf));
    chk("R10 eng_rx_ready", 32'(eng_rx_ready), 32'(rs < cap));

    txfl = tx_flush_cmd || fifo_on_cmd || fifo_off_cmd;
    rxfl = rx_flush_cmd || fifo_on_cmd || fifo_off_cmd;
    tx_pop = exp_v && eng_tx_ready;
    room = cap - ts + int'(tx_pop);
    need = (m_on && bus_wr_wide) ? 4 : 1;
    tx_acc = bus_wr_en && !txfl && (room >= need);
    ovf_evt = bus_wr_en && !txfl && !tx_acc;
    rneed = (m_on && bus_rd_wide) ? 4 : 1;
    rx_acc = bus_rd_en && !rxfl && (rs >= rneed);
    udf_evt = bus_rd_en && !rxfl && !rx_acc;
    rx_push = eng_rx_valid && (rs < cap);
    if (bus_rd_en) begin
      if (rx_acc) exp_rd = (rneed == 4) ? {rxq[3], rxq[2], rxq[1], rxq[0]} : {24'h0, rxq[0]};
      else        exp_rd = (rneed == 4) ? {4{m_last}} : {24'h0, m_last};
      chk((rneed == 4) ? "R6 wide bus_rd_data" : "R5 bus_rd_data", bus_rd_data, exp_rd);
    end

    if (txfl) txq.delete();
    else begin
      if (tx_pop) void'(txq.pop_front());
      if (tx_acc) for (int k = 0; k < need; k++) txq.push_back(bus_wr_data[8*k +: 8]);
    end
    if (rxfl) rxq.delete();
    else begin
      if (rx_acc) for (int k = 0; k < rneed; k++) m_last = rxq.pop_front();
      if (rx_push) rxq.push_back(eng_rx_data);
    end
    m_lock = nack_set || (m_lock && !lock_clr_cmd);
    m_ovf = ovf_evt || (m_ovf && !status_rd);
    m_udf = udf_evt || (m_udf && !status_rd);
    if (fifo_off_cmd) m_on = 0;
    else if (fifo_on_cmd) m_on = 1;
    @(negedge clk);
  endtask

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle();
    tx_four_mode = 0; rx_four_mode = 0;
    rst_n = 0;
    m_on = 0; m_lock = 0; m_ovf = 0; m_udf = 0; m_last = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 fifo_on", 32'(fifo_on), 0);
    chk("R1 lock_flag", 32'(lock_flag), 0);
    chk("R1 errors", {30'h0, tx_ovf_err, rx_udf_err}, 0);
    chk("R1 tx_rdy", 32'(tx_rdy), 1);
    chk("R1 rx_rdy", 32'(rx_rdy), 0);
    @(negedge clk);

    // single-entry mode: second write overflows (R9), wide treated as byte (R6)
    idle(); bus_wr_en = 1; bus_wr_wide = 1; bus_wr_data = 32'hA1B2C3D4; cycle();
    idle(); bus_wr_en = 1; bus_wr_data = 32'h55; tx_four_mode = 1; cycle();
    idle(); status_rd = 1; eng_tx_ready = 1; cycle();
    idle(); eng_rx_valid = 1; eng_rx_data = 8'h3C; cycle();
    idle(); eng_rx_valid = 1; eng_rx_data = 8'h99; cycle();
    idle(); bus_rd_en = 1; bus_rd_wide = 1; cycle();
    idle(); bus_rd_en = 1; cycle();
    idle(); status_rd = 1; cycle();

    // FIFO mode: fill with wide writes, then overflow on partial room (R6, R3)
    idle(); fifo_on_cmd = 1; cycle();
    for (int i = 0; i < 4; i++) begin
      idle(); bus_wr_en = 1; bus_wr_wide = 1; bus_wr_data = $urandom; cycle();
    end
    idle(); bus_wr_en = 1; bus_wr_data = 32'h77; cycle();
    // R10 same-cycle pop frees a slot for a write on a full FIFO
    idle(); eng_tx_ready = 1; bus_wr_en = 1; bus_wr_data = 32'h42; cycle();
    idle(); eng_tx_ready = 1; cycle();
    idle(); bus_wr_en = 1; bus_wr_wide = 1; bus_wr_data = 32'h01020304; cycle();
    // R8 lock: engine ready but nothing offered; set wins over clear
    idle(); nack_set = 1; lock_clr_cmd = 1; cycle();
    idle(); eng_tx_ready = 1; bus_wr_en = 1; cycle();
    idle(); eng_tx_ready = 1; lock_clr_cmd = 1; tx_flush_cmd = 1; cycle();
    idle(); eng_tx_ready = 1; cycle();

    // receive side: wide read with too few bytes, then success (R6, R9, R4)
    rx_four_mode = 1;
    for (int i = 0; i < 3; i++) begin
      idle(); eng_rx_valid = 1; eng_rx_data = 8'(8'h10 + i); cycle();
    end
    idle(); bus_rd_en = 1; bus_rd_wide = 1; cycle();
    idle(); eng_rx_valid = 1; eng_rx_data = 8'h13; status_rd = 1; cycle();
    idle(); bus_rd_en = 1; bus_rd_wide = 1; cycle();
    // R7 both flushes together drop same-cycle traffic
    idle(); eng_rx_valid = 1; cycle();
    idle(); tx_flush_cmd = 1; rx_flush_cmd = 1; bus_wr_en = 1; bus_rd_en = 1; eng_rx_valid = 1; cycle();
    idle(); cycle();
    // R2 on and off together: off wins
    idle(); fifo_on_cmd = 1; fifo_off_cmd = 1; cycle();
    idle(); cycle();

    // constrained random phase
    for (int n = 0; n < 5000; n++) begin
      idle();
      fifo_on_cmd  = ($urandom % 70) == 0;
      fifo_off_cmd = ($urandom % 200) == 0;
      tx_flush_cmd = ($urandom % 45) == 0;
      rx_flush_cmd = ($urandom % 45) == 0;
      lock_clr_cmd = ($urandom % 10) == 0;
      nack_set     = ($urandom % 60) == 0;
      status_rd    = ($urandom % 8) == 0;
      bus_wr_en    = ($urandom % 2) == 0;
      bus_wr_wide  = ($urandom % 2) == 0;
      bus_wr_data  = $urandom;
      bus_rd_en    = ($urandom % 3) == 0;
      bus_rd_wide  = ($urandom % 2) == 0;
      eng_tx_ready = ($urandom % 3) == 0;
      eng_rx_valid = ($urandom % 2) == 0;
      eng_rx_data  = 8'($urandom);
      if (($urandom % 50) == 0) tx_four_mode = ~tx_four_mode;
      if (($urandom % 50) == 0) rx_four_mode = ~rx_four_mode;
      cycle();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule